// File: doc/BRIEF.md
# Fixed-Point Narrowing Stage

This block takes a wide fixed-point word from an upstream filter and turns it into a short word in one registered step. The first part of the path is a relabelling only. The incoming bits are read in a chosen view format: a chosen signedness and a chosen number of fraction bits. No bit is changed. For example, reading a 43-bit word with 28 fraction bits as if it had 27 fraction bits doubles the value it stands for. The second part converts that view value into a narrower output format while keeping the value. Where the value must change, it does so by a selectable quantization rule and a selectable overflow policy.

All formats and policies are elaboration parameters. By default the input is 43 bits, viewed as signed with 27 fraction bits. The output is 16 signed bits with 13 fraction bits, which covers about plus or minus 4 and so leaves room for the doubled range. The default rounding is half away from zero, and the default overflow policy is saturation.

Both data sides use a valid/ready handshake. A word moves on a clock edge where valid and ready are both high. The stage holds one result. `in_ready` is high when the output register is empty, or when the output is being taken in that same cycle. While `out_valid` is high and `out_ready` is low, the output word and its flag stay frozen.

Top module: `fxp_narrow_stage`

## Requirements
- R1: The view value equals the input bits read with VIEW_FRAC fraction bits, as two's complement when VIEW_SIGNED is 1 and as unsigned when it is 0. With the defaults, input 2^28 (1.0 with 28 fraction bits) gives output code 0x4000 (2.0 with 13 fraction bits). An all-ones input reads as -1 LSB when signed and as 2^43-1 when unsigned.
- R2: In truncate mode the view value is rounded toward minus infinity to the output LSB. For example, -1 view LSB gives output -1 (0xFFFF).
- R3: In round mode a value exactly half an output LSB from a code moves away from zero (+0.5 LSB to 1, -1.5 LSB to -2). Any other value goes to the nearest code.
- R4: In saturate mode a result above the output range gives the most positive code, and one below it gives the most negative code (signed 16-bit: 0x7FFF and 0x8000). `out_ovf` stays 0.
- R5: In wrap mode the output is the low OUT_W bits of the quantized value. For example, +32768 LSB gives 0x8000. `out_ovf` stays 0.
- R6: In flag mode the output wraps as in R5. `out_ovf` is 1 exactly with the output word whose quantized value was out of range, and is 0 with every other word.
- R7: With OUT_SIGNED at 0 the output range is 0 to 2^OUT_W-1. A value that rounds up to 2^OUT_W is out of range.
- R8: A word accepted on one clock edge is on the output with `out_valid` high after that edge. With no new input and `out_ready` high, `out_valid` falls after the next edge.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_ovf` hold their values and `in_ready` is low. A stalled input is taken once the output drains.
- R10: During reset and right after it, `out_valid` and `out_ovf` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Stage can take an input word |
| in_data | input | IN_W | Raw wide input bits |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream takes the output word |
| out_data | output | OUT_W | Narrowed output word |
| out_ovf | output | 1 | Overflow flag for this output word (flag mode only) |

## Verification
Three instances with different parameters get the same stream. The first uses signed data with round and saturate. The second uses signed data with truncate and wrap. The third uses an unsigned view with round and flag. Values at exactly plus and minus half an LSB and at one and a half LSB separate round from truncate and check that ties move away from zero. Values one LSB above the signed maximum and one below the signed minimum separate saturation from wrapping. A value that only overflows once rounded checks that the range test is applied after quantization. The all-ones word separates the signed view from the unsigned one. It also drives the flag path, because it overflows the unsigned output. A stall of several cycles with a second word waiting shows that the output word is held and that nothing is lost or duplicated.

// File: rtl/fxp_pkg.sv
package fxp_pkg;
  typedef enum logic { Q_TRUNC, Q_ROUND } qmode_e;
  typedef enum logic [1:0] { O_WRAP, O_SAT, O_FLAG } omode_e;
endpackage

// File: rtl/fxp_view.sv
// Relabels raw bits in the view signedness and extends them; bits are unchanged.
module fxp_view #(
  parameter int IN_W        = 43,
  parameter int EW          = 45,
  parameter bit VIEW_SIGNED = 1'b1
) (
  input  logic [IN_W-1:0]        raw,
  output logic signed [EW-1:0]   ext
);
  generate
    if (VIEW_SIGNED) begin : g_signed
      assign ext = {{(EW-IN_W){raw[IN_W-1]}}, raw};
    end else begin : g_unsigned
      assign ext = {{(EW-IN_W){1'b0}}, raw};
    end
  endgenerate
endmodule

// File: rtl/fxp_requant.sv
// Moves the view value to the output binary point with truncation or rounding.
module fxp_requant #(
  parameter int             EW    = 45,
  parameter int             SH    = 14,
  parameter fxp_pkg::qmode_e QMODE = fxp_pkg::Q_ROUND
) (
  input  logic signed [EW-1:0] ext,
  output logic signed [EW-1:0] q
);
  localparam logic signed [EW-1:0] ONE = {{(EW-1){1'b0}}, 1'b1};

  generate
    if (SH > 0) begin : g_down
      if (QMODE == fxp_pkg::Q_ROUND) begin : g_round
        localparam logic signed [EW-1:0] HALF = ONE <<< (SH - 1);
        logic signed [EW-1:0] biased;
        // negative values take half minus one so the floor shift moves ties away from zero
        assign biased = ext + (ext[EW-1] ? (HALF - ONE) : HALF);
        assign q      = biased >>> SH;
      end else begin : g_trunc
        assign q = ext >>> SH;
      end
    end else if (SH == 0) begin : g_same
      assign q = ext;
    end else begin : g_up
      assign q = ext <<< (-SH);
    end
  endgenerate
endmodule

// File: rtl/fxp_clamp.sv
// Range test against the output format and the overflow policy on the data word.
module fxp_clamp #(
  parameter int              EW         = 45,
  parameter int              OUT_W      = 16,
  parameter bit              OUT_SIGNED = 1'b1,
  parameter fxp_pkg::omode_e OMODE      = fxp_pkg::O_SAT
) (
  input  logic signed [EW-1:0] q,
  output logic [OUT_W-1:0]     y,
  output logic                 over
);
  localparam logic signed [EW-1:0] ONE  = {{(EW-1){1'b0}}, 1'b1};
  localparam logic signed [EW-1:0] MAXV = OUT_SIGNED ? ((ONE <<< (OUT_W-1)) - ONE)
                                                     : ((ONE <<< OUT_W) - ONE);
  localparam logic signed [EW-1:0] MINV = OUT_SIGNED ? -(ONE <<< (OUT_W-1))
                                                     : {EW{1'b0}};

  logic above, below;
  assign above = q > MAXV;
  assign below = q < MINV;
  assign over  = above | below;

  generate
    if (OMODE == fxp_pkg::O_SAT) begin : g_sat
      always_comb begin
        if (above)      y = MAXV[OUT_W-1:0];
        else if (below) y = MINV[OUT_W-1:0];
        else            y = q[OUT_W-1:0];
      end
    end else begin : g_wrap
      assign y = q[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/fxp_narrow_stage.sv
module fxp_narrow_stage #(
  parameter int              IN_W        = 43,
  parameter int              VIEW_FRAC   = 27,
  parameter bit              VIEW_SIGNED = 1'b1,
  parameter int              OUT_W       = 16,
  parameter int              OUT_FRAC    = 13,
  parameter bit              OUT_SIGNED  = 1'b1,
  parameter fxp_pkg::qmode_e QMODE       = fxp_pkg::Q_ROUND,
  parameter fxp_pkg::omode_e OMODE       = fxp_pkg::O_SAT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data,
  output logic             out_ovf
);
  localparam int SH   = VIEW_FRAC - OUT_FRAC;
  localparam int LSH  = (SH < 0) ? -SH : 0;
  localparam int EW_A = IN_W + 2 + LSH;
  localparam int EW   = (EW_A > OUT_W + 2) ? EW_A : OUT_W + 2;

  logic signed [EW-1:0] ext, q;
  logic [OUT_W-1:0]     y;
  logic                 over;

  fxp_view #(.IN_W(IN_W), .EW(EW), .VIEW_SIGNED(VIEW_SIGNED)) u_view (
    .raw(in_data), .ext(ext)
  );

  fxp_requant #(.EW(EW), .SH(SH), .QMODE(QMODE)) u_requant (
    .ext(ext), .q(q)
  );

  fxp_clamp #(.EW(EW), .OUT_W(OUT_W), .OUT_SIGNED(OUT_SIGNED), .OMODE(OMODE)) u_clamp (
    .q(q), .y(y), .over(over)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ovf   <= 1'b0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_data  <= y;
      out_ovf   <= (OMODE == fxp_pkg::O_FLAG) && over;
    end else if (out_ready) begin
      out_valid <= 1'b0;
      out_ovf   <= 1'b0;
    end
  end

  // R9: a stalled output word is frozen
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_ovf));

  // R8: an accepted word is presented after one edge
  a_r8_accept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R8: valid only drops after a transfer
  a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready));

  // R6: the flag only travels with a valid word
  a_r6_flag_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_ovf |-> out_valid);
endmodule

// File: tb/sim_fxp_narrow_stage.sv
module sim_fxp_narrow_stage;
  import fxp_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [42:0] in_data = '0;
  logic        out_ready = 1'b1;
  logic        rdy0, rdy1, rdy2, ov0, ov1, ov2, of0, of1, of2;
  logic [15:0] od0, od1, od2;

  fxp_narrow_stage u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy0), .in_data(in_data),
    .out_valid(ov0), .out_ready(out_ready), .out_data(od0), .out_ovf(of0));

  fxp_narrow_stage #(.QMODE(Q_TRUNC), .OMODE(O_WRAP)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy1), .in_data(in_data),
    .out_valid(ov1), .out_ready(out_ready), .out_data(od1), .out_ovf(of1));

  fxp_narrow_stage #(.VIEW_SIGNED(1'b0), .OUT_SIGNED(1'b0), .QMODE(Q_ROUND), .OMODE(O_FLAG)) u2 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy2), .in_data(in_data),
    .out_valid(ov2), .out_ready(out_ready), .out_data(od2), .out_ovf(of2));

  typedef struct {
    logic [15:0] y0, y1, y2;
    bit          f0, f1, f2;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0;
  int          fails  = 0;
  logic [15:0] last0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // om: 0 wrap, 1 saturate, 2 flag
  function automatic void model(input logic [42:0] d, input bit vs, input bit os,
                                input bit rnd, input int om,
                                output logic [15:0] y, output bit f);
    longint v, q, hi, lo;
    bit over;
    v = vs ? longint'($signed(d)) : longint'({21'b0, d});
    if (rnd) q = (v >= 0) ? ((v + 8192) >>> 14) : -((-v + 8192) >>> 14);
    else     q = v >>> 14;
    hi = os ? 32767 : 65535;
    lo = os ? -32768 : 0;
    over = (q > hi) || (q < lo);
    if (om == 1 && q > hi)      y = hi[15:0];
    else if (om == 1 && q < lo) y = lo[15:0];
    else                        y = q[15:0];
    f = (om == 2) && over;
  endfunction

  task automatic send(input longint raw, input string tag);
    exp_t e;
    @(posedge clk); #1;
    in_valid = 1'b1;
    in_data  = raw[42:0];
    model(raw[42:0], 1'b1, 1'b1, 1'b1, 1, e.y0, e.f0);
    model(raw[42:0], 1'b1, 1'b1, 1'b0, 0, e.y1, e.f1);
    model(raw[42:0], 1'b0, 1'b0, 1'b1, 2, e.y2, e.f2);
    e.tag = tag;
    sb.push_back(e);
    do @(negedge clk); while (!rdy0);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  always @(negedge clk) begin : monitor
    exp_t e;
    if (rst_n && ov0 && out_ready) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R8", "unexpected output word", 1, 0);
      end else begin
        e = sb.pop_front();
        chk(ov1 && ov2, e.tag, "valid alignment", longint'({ov1, ov2}), 3);
        chk(od0 == e.y0, e.tag, "u0 data", od0, e.y0);
        chk(of0 == e.f0, e.tag, "u0 flag", of0, e.f0);
        chk(od1 == e.y1, e.tag, "u1 data", od1, e.y1);
        chk(of1 == e.f1, e.tag, "u1 flag", of1, e.f1);
        chk(od2 == e.y2, e.tag, "u2 data", od2, e.y2);
        chk(of2 == e.f2, e.tag, "u2 flag", of2, e.f2);
        last0 = od0;
      end
    end
  end

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [15:0] snap;
    repeat (3) @(posedge clk);
    // R10: reset state
    @(negedge clk);
    chk(!ov0 && !of0, "R10", "out_valid/out_ovf in reset", longint'({ov0, of0}), 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!ov0 && !ov2 && rdy0, "R10", "state after reset", longint'({ov0, ov2, rdy0}), 1);

    // R1: binary point move doubles the value
    send(268435456, "R1");
    drain();
    chk(last0 == 16'h4000, "R1", "1.0 reads as 2.0", last0, 16'h4000);
    send(-1, "R1");            // all ones: signed -1 LSB vs unsigned 2^43-1
    // R2 / R3: quantization
    send(8192, "R3");
    send(-8192, "R3");
    send(24576, "R3");
    send(-24576, "R3");
    send(-8191, "R2");
    send(8191, "R2");
    send(-16385, "R2");
    // R4 / R5: overflow policies
    send(536870912, "R4");
    send(-536887296, "R5");
    send(536862720, "R4");
    // R6 / R7: unsigned output and flag
    send(1073725440, "R7");
    send(1073733632, "R6");
    send(1073733631, "R7");
    drain();

    // R8: one edge of latency, valid falls after transfer
    send(16384, "R8");
    chk(ov0, "R8", "valid after accept edge", ov0, 1);
    @(posedge clk); #1;
    chk(!ov0, "R8", "valid after drain", ov0, 0);
    drain();

    // R9: back-pressure
    @(posedge clk); #1;
    out_ready = 1'b0;
    send(49152, "R9");
    fork
      send(-49152, "R9");
      begin
        @(negedge clk);
        snap = od0;
        repeat (3) begin
          @(negedge clk);
          chk(ov0 && !rdy0 && od0 == snap, "R9", "stall hold",
              longint'({ov0, rdy0}), 2);
          chk(od0 == snap, "R9", "stall data", od0, snap);
        end
        @(posedge clk); #1;
        out_ready = 1'b1;
      end
    join
    drain();
    chk(sb.size() == 0, "R9", "scoreboard empty", sb.size(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule